// File: doc/BRIEF.md
# Dual-Bank Paired-Access Register File

This block provides register storage for a datapath with two independent banks, A and B. Each bank holds sixteen 32-bit registers. It returns and accepts single 32-bit words. It also returns and accepts wide operands of 40 or 64 bits, which are built from an aligned even/odd pair of registers. In a wide operand the even register always holds the low word. The odd register holds either the full upper word (64-bit) or only the upper byte (40-bit).

Each bank has one write port and two read ports. Each port has its own width select.

- The write port splits a wide value into the two halves of the pair and masks the upper half to suit the selected width. Both registers of the pair change on the same clock edge.
- Each read port puts the pair back together, zero-extended to 64 bits.
- An access to a wide pair with an odd address is rejected. So is an access with the unused width code.
- Reads are combinational from the stored state. A read in the same cycle as a write to the same register therefore returns the value from before the write.

Instruction decode, lane arithmetic, movement between banks and forwarding are handled elsewhere. A 32-bit word that carries two 16-bit halves is stored like any other word.

Top module: `dual_bank_regfile`

## Requirements
- R1: Bank 0 (A) and bank 1 (B) each hold 16 registers of 32 bits. A write on one bank's port never alters the other bank. Equal register numbers in the two banks are separate storage.
- R2: Width code 0 (32-bit) writes wr_data[31:0] into the addressed register only; any address 0..15 is legal. A read with width code 0 returns {32'h0, register}, bit-exact, with no sign extension of either 16-bit half.
- R3: Width code 2 (64-bit) with an even address a writes wr_data[31:0] into register a and wr_data[63:32] into register a+1 on the same clock edge.
- R4: Width code 1 (40-bit) with an even address a writes wr_data[31:0] into register a and {24'h0, wr_data[39:32]} into register a+1, clearing bits 31:8 of the odd register.
- R5: With an even address a, a read with width code 1 returns {24'h0, reg[a+1][7:0], reg[a]}. A read with width code 2 returns {reg[a+1], reg[a]}.
- R6: A width 1 or 2 access with an odd address is illegal. On a write, wr_err for that bank is high in that cycle and no register changes. On a read, rd_err for that port is high and rd_data is zero.
- R7: Width code 3 is invalid for every address. It behaves as in R6: the write is suppressed with wr_err high, and the read returns zero with rd_err high.
- R8: Writes take effect at the rising clock edge. A read of the written register in the same cycle returns the old value, and the new value is visible after the edge.
- R9: While rst is high at a rising edge, every register in both banks is cleared to zero.
- R10: The two read ports of a bank operate independently, each with its own address and width, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 2 | Write enable, one bit per bank (bit 0 = A) |
| wr_width | input | 2x2 | Write width code per bank: 0=32, 1=40, 2=64, 3=invalid |
| wr_addr | input | 2x4 | Write register number per bank |
| wr_data | input | 2x64 | Write data per bank, low word in bits 31:0 |
| wr_err | output | 2 | Illegal write flag per bank, same cycle |
| rd_addr | input | 2x2x4 | Read register number per bank and port |
| rd_width | input | 2x2x2 | Read width code per bank and port |
| rd_data | output | 2x2x64 | Read data per bank and port, zero-extended |
| rd_err | output | 2x2 | Illegal read flag per bank and port |

## Verification
Single-word writes use values with both 16-bit halves above 0x7FFF. This separates clean storage from any sign or half-word handling. Pair writes carry non-zero garbage above bit 39, and the odd register is pre-filled with ones before the 40-bit write. This tells 40-bit masking apart from 64-bit pass-through and from a merge that leaves old bits in place. Odd-address wide accesses and the unused width code are sent after known data has been stored. Reads in the same cycle as a write, and the same register number written in both banks at once, separate timing errors from errors in bank selection.

// File: rtl/dual_bank_regfile_pkg.sv
package dual_bank_regfile_pkg;

   typedef enum logic [1:0] {
      WSEL_32  = 2'd0,
      WSEL_40  = 2'd1,
      WSEL_64  = 2'd2,
      WSEL_BAD = 2'd3
   } wsel_e;

endpackage

// File: rtl/rf_write_shaper.sv
module rf_write_shaper
   import dual_bank_regfile_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NREGS    = 16,
   parameter int EXT_BITS = 8,
   localparam int AW      = $clog2(NREGS)
) (
   input  logic                  en,
   input  logic [1:0]            width,
   input  logic [AW-1:0]         addr,
   input  logic [2*DATA_W-1:0]   data,
   output logic                  lo_we,
   output logic [AW-1:0]         lo_idx,
   output logic [DATA_W-1:0]     lo_data,
   output logic                  hi_we,
   output logic [AW-1:0]         hi_idx,
   output logic [DATA_W-1:0]     hi_data,
   output logic                  err
);

   logic [DATA_W-1:0] ext_word;

   generate
      if (EXT_BITS < DATA_W) begin : g_ext_pad
         assign ext_word = {{(DATA_W-EXT_BITS){1'b0}}, data[DATA_W +: EXT_BITS]};
      end else begin : g_ext_full
         assign ext_word = data[DATA_W +: DATA_W];
      end
   endgenerate

   assign lo_idx  = addr;
   assign hi_idx  = {addr[AW-1:1], 1'b1};
   assign lo_data = data[DATA_W-1:0];

   always_comb begin
      lo_we   = 1'b0;
      hi_we   = 1'b0;
      err     = 1'b0;
      hi_data = data[DATA_W +: DATA_W];
      case (wsel_e'(width))
         WSEL_32: lo_we = en;
         WSEL_40: begin
            hi_data = ext_word;
            if (addr[0]) begin
               err = en;
            end else begin
               lo_we = en;
               hi_we = en;
            end
         end
         WSEL_64: begin
            if (addr[0]) begin
               err = en;
            end else begin
               lo_we = en;
               hi_we = en;
            end
         end
         default: err = en;
      endcase
   end

endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
   parameter int DATA_W = 32,
   parameter int NREGS  = 16,
   localparam int AW    = $clog2(NREGS)
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         lo_we,
   input  logic [AW-1:0]                lo_idx,
   input  logic [DATA_W-1:0]            lo_data,
   input  logic                         hi_we,
   input  logic [AW-1:0]                hi_idx,
   input  logic [DATA_W-1:0]            hi_data,
   output logic [NREGS-1:0][DATA_W-1:0] regs
);

   always_ff @(posedge clk) begin
      if (rst) begin
         regs <= '0;
      end else begin
         if (lo_we) regs[lo_idx] <= lo_data;
         if (hi_we) regs[hi_idx] <= hi_data;
      end
   end

endmodule

// File: rtl/rf_read_assembler.sv
module rf_read_assembler
   import dual_bank_regfile_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int NREGS    = 16,
   parameter int EXT_BITS = 8,
   localparam int AW      = $clog2(NREGS)
) (
   input  logic [NREGS-1:0][DATA_W-1:0] regs,
   input  logic [AW-1:0]                addr,
   input  logic [1:0]                   width,
   output logic [2*DATA_W-1:0]          data,
   output logic                         err
);

   logic [AW-1:0]     odd_idx;
   logic [DATA_W-1:0] odd_ext;

   assign odd_idx = {addr[AW-1:1], 1'b1};

   generate
      if (EXT_BITS < DATA_W) begin : g_ext_pad
         assign odd_ext = {{(DATA_W-EXT_BITS){1'b0}}, regs[odd_idx][EXT_BITS-1:0]};
      end else begin : g_ext_full
         assign odd_ext = regs[odd_idx];
      end
   endgenerate

   always_comb begin
      data = '0;
      err  = 1'b0;
      case (wsel_e'(width))
         WSEL_32: data[DATA_W-1:0] = regs[addr];
         WSEL_40: begin
            if (addr[0]) err = 1'b1;
            else         data = {odd_ext, regs[addr]};
         end
         WSEL_64: begin
            if (addr[0]) err = 1'b1;
            else         data = {regs[odd_idx], regs[addr]};
         end
         default: err = 1'b1;
      endcase
   end

endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile #(
   parameter int DATA_W    = 32,
   parameter int NREGS     = 16,
   parameter int NUM_BANKS = 2,
   parameter int RD_PORTS  = 2,
   parameter int EXT_BITS  = 8,
   localparam int AW       = $clog2(NREGS),
   localparam int WIDE_W   = 2 * DATA_W
) (
   input  logic                                        clk,
   input  logic                                        rst,
   input  logic [NUM_BANKS-1:0]                        wr_en,
   input  logic [NUM_BANKS-1:0][1:0]                   wr_width,
   input  logic [NUM_BANKS-1:0][AW-1:0]                wr_addr,
   input  logic [NUM_BANKS-1:0][WIDE_W-1:0]            wr_data,
   output logic [NUM_BANKS-1:0]                        wr_err,
   input  logic [NUM_BANKS-1:0][RD_PORTS-1:0][AW-1:0]  rd_addr,
   input  logic [NUM_BANKS-1:0][RD_PORTS-1:0][1:0]     rd_width,
   output logic [NUM_BANKS-1:0][RD_PORTS-1:0][WIDE_W-1:0] rd_data,
   output logic [NUM_BANKS-1:0][RD_PORTS-1:0]          rd_err
);

   generate
      if (NREGS < 2 || (NREGS & (NREGS - 1)) != 0) begin : g_bad_nregs
         $error("NREGS must be a power of two of at least 2");
      end
      if (EXT_BITS < 1 || EXT_BITS > DATA_W) begin : g_bad_ext
         $error("EXT_BITS must lie in 1..DATA_W");
      end
      if (NUM_BANKS < 1 || RD_PORTS < 1) begin : g_bad_counts
         $error("NUM_BANKS and RD_PORTS must be positive");
      end
   endgenerate

   logic [NUM_BANKS-1:0][NREGS-1:0][DATA_W-1:0] bank_regs;

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic              lo_we, hi_we;
         logic [AW-1:0]     lo_idx, hi_idx;
         logic [DATA_W-1:0] lo_data, hi_data;

         rf_write_shaper #(
            .DATA_W(DATA_W), .NREGS(NREGS), .EXT_BITS(EXT_BITS)
         ) shaper_i (
            .en(wr_en[b]), .width(wr_width[b]), .addr(wr_addr[b]), .data(wr_data[b]),
            .lo_we(lo_we), .lo_idx(lo_idx), .lo_data(lo_data),
            .hi_we(hi_we), .hi_idx(hi_idx), .hi_data(hi_data),
            .err(wr_err[b])
         );

         rf_bank #(
            .DATA_W(DATA_W), .NREGS(NREGS)
         ) bank_i (
            .clk(clk), .rst(rst),
            .lo_we(lo_we), .lo_idx(lo_idx), .lo_data(lo_data),
            .hi_we(hi_we), .hi_idx(hi_idx), .hi_data(hi_data),
            .regs(bank_regs[b])
         );

         for (genvar p = 0; p < RD_PORTS; p++) begin : g_rport
            rf_read_assembler #(
               .DATA_W(DATA_W), .NREGS(NREGS), .EXT_BITS(EXT_BITS)
            ) rd_i (
               .regs(bank_regs[b]), .addr(rd_addr[b][p]), .width(rd_width[b][p]),
               .data(rd_data[b][p]), .err(rd_err[b][p])
            );
         end
      end
   endgenerate

endmodule

// File: rtl/dual_bank_regfile_chk.sv
module dual_bank_regfile_chk #(
   parameter int DATA_W    = 32,
   parameter int NREGS     = 16,
   parameter int NUM_BANKS = 2,
   parameter int RD_PORTS  = 2,
   parameter int EXT_BITS  = 8,
   localparam int AW       = $clog2(NREGS),
   localparam int WIDE_W   = 2 * DATA_W
) (
   input logic                                           clk,
   input logic                                           rst,
   input logic [NUM_BANKS-1:0]                           wr_en,
   input logic [NUM_BANKS-1:0][1:0]                      wr_width,
   input logic [NUM_BANKS-1:0][AW-1:0]                   wr_addr,
   input logic [NUM_BANKS-1:0][WIDE_W-1:0]               wr_data,
   input logic [NUM_BANKS-1:0]                           wr_err,
   input logic [NUM_BANKS-1:0][RD_PORTS-1:0][AW-1:0]     rd_addr,
   input logic [NUM_BANKS-1:0][RD_PORTS-1:0][1:0]        rd_width,
   input logic [NUM_BANKS-1:0][RD_PORTS-1:0][WIDE_W-1:0] rd_data,
   input logic [NUM_BANKS-1:0][RD_PORTS-1:0]             rd_err,
   input logic [NUM_BANKS-1:0][NREGS-1:0][DATA_W-1:0]    regs
);

   AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (regs == '0)); // R9

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
         AST_IDLE_BANK_STABLE: assert property (@(posedge clk) disable iff (rst)
            !wr_en[b] |=> $stable(regs[b])); // R1

         AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
            (wr_en[b] && wr_width[b] == 2'd0)
            |=> regs[b][$past(wr_addr[b])] == $past(wr_data[b][DATA_W-1:0])); // R2

         AST_PAIR64_WRITE: assert property (@(posedge clk) disable iff (rst)
            (wr_en[b] && wr_width[b] == 2'd2 && !wr_addr[b][0])
            |=> regs[b][{$past(wr_addr[b][AW-1:1]), 1'b1}] == $past(wr_data[b][WIDE_W-1:DATA_W])); // R3

         AST_PAIR40_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
            (wr_en[b] && wr_width[b] == 2'd1 && !wr_addr[b][0])
            |=> regs[b][{$past(wr_addr[b][AW-1:1]), 1'b1}][DATA_W-1:EXT_BITS] == '0); // R4

         AST_ODD_PAIR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
            (wr_en[b] && wr_width[b] != 2'd0 && wr_addr[b][0])
            |=> $stable(regs[b])); // R6

         AST_BAD_WIDTH_BLOCKED: assert property (@(posedge clk) disable iff (rst)
            (wr_en[b] && wr_width[b] == 2'd3) |-> wr_err[b] ##1 $stable(regs[b])); // R7

         for (genvar p = 0; p < RD_PORTS; p++) begin : g_p
            AST_ODD_PAIR_READ: assert property (@(posedge clk) disable iff (rst)
               (rd_width[b][p] != 2'd0 && rd_addr[b][p][0])
               |-> (rd_err[b][p] && rd_data[b][p] == '0)); // R6

            AST_PAIR64_READ_LOW: assert property (@(posedge clk) disable iff (rst)
               (rd_width[b][p] == 2'd2 && !rd_addr[b][p][0])
               |-> rd_data[b][p][DATA_W-1:0] == regs[b][rd_addr[b][p]]); // R5
         end
      end
   endgenerate

endmodule

bind dual_bank_regfile dual_bank_regfile_chk #(
   .DATA_W(DATA_W), .NREGS(NREGS), .NUM_BANKS(NUM_BANKS),
   .RD_PORTS(RD_PORTS), .EXT_BITS(EXT_BITS)
) chk_i (
   .clk(clk), .rst(rst), .wr_en(wr_en), .wr_width(wr_width), .wr_addr(wr_addr),
   .wr_data(wr_data), .wr_err(wr_err), .rd_addr(rd_addr), .rd_width(rd_width),
   .rd_data(rd_data), .rd_err(rd_err), .regs(bank_regs)
);

// File: tb/dual_bank_regfile_tb_top.sv
module dual_bank_regfile_tb_top;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #5 clk = ~clk;

   logic [1:0]             wr_en = '0;
   logic [1:0][1:0]        wr_width = '0;
   logic [1:0][3:0]        wr_addr = '0;
   logic [1:0][63:0]       wr_data = '0;
   logic [1:0]             wr_err;
   logic [1:0][1:0][3:0]   rd_addr = '0;
   logic [1:0][1:0][1:0]   rd_width = '0;
   logic [1:0][1:0][63:0]  rd_data;
   logic [1:0][1:0]        rd_err;

   dual_bank_regfile dut_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_width(wr_width), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_err(wr_err), .rd_addr(rd_addr), .rd_width(rd_width),
      .rd_data(rd_data), .rd_err(rd_err)
   );

   typedef struct {
      string      tag;
      bit         is_wr;
      int         b;
      int         p;
      logic [63:0] exp_d;
      logic       exp_e;
   } item_t;

   item_t q[$];
   event  mon_ev;
   int    n_cmp = 0;
   int    n_bad = 0;

   logic [31:0] model [2][16];
   bit          pend [2];
   bit          pend_err [2];
   int          pend_w [2];
   int          pend_a [2];
   logic [63:0] pend_d [2];

   // scoreboard monitor
   initial begin
      forever begin
         @(mon_ev);
         #1;
         while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_cmp++;
            if (it.is_wr) begin
               if (wr_err[it.b] !== it.exp_e) begin
                  n_bad++;
                  $display("FAIL %s: wr_err[%0d] actual %b expected %b", it.tag, it.b,
                           wr_err[it.b], it.exp_e);
               end
            end else if (rd_data[it.b][it.p] !== it.exp_d || rd_err[it.b][it.p] !== it.exp_e) begin
               n_bad++;
               $display("FAIL %s: bank %0d port %0d actual %h/%b expected %h/%b", it.tag,
                        it.b, it.p, rd_data[it.b][it.p], rd_err[it.b][it.p], it.exp_d, it.exp_e);
            end
         end
      end
   end

   function automatic bit is_bad(int w, int a);
      return (w == 3) || (w != 0 && a[0]);
   endfunction

   function automatic logic [63:0] exp_read(int b, int a, int w);
      int o;
      o = a | 1;
      if (is_bad(w, a)) return 64'h0;
      case (w)
         0:       return {32'h0, model[b][a]};
         1:       return {24'h0, model[b][o][7:0], model[b][a]};
         default: return {model[b][o], model[b][a]};
      endcase
   endfunction

   task automatic do_read(int b, int p, int a, int w, string tag);
      item_t it;
      rd_addr[b][p]  = 4'(a);
      rd_width[b][p] = 2'(w);
      it.tag = tag; it.is_wr = 1'b0; it.b = b; it.p = p;
      it.exp_d = exp_read(b, a, w);
      it.exp_e = is_bad(w, a);
      q.push_back(it);
      -> mon_ev;
      #2;
   endtask

   task automatic wr_drive(int b, int w, int a, logic [63:0] d, string tag);
      item_t it;
      wr_en[b] = 1'b1; wr_width[b] = 2'(w); wr_addr[b] = 4'(a); wr_data[b] = d;
      pend[b] = 1'b1; pend_w[b] = w; pend_a[b] = a; pend_d[b] = d;
      pend_err[b] = is_bad(w, a);
      it.tag = tag; it.is_wr = 1'b1; it.b = b; it.p = 0; it.exp_d = '0;
      it.exp_e = is_bad(w, a);
      q.push_back(it);
      -> mon_ev;
      #2;
   endtask

   task automatic wr_commit();
      @(posedge clk);
      for (int b = 0; b < 2; b++) begin
         if (pend[b] && !pend_err[b]) begin
            model[b][pend_a[b]] = pend_d[b][31:0];
            if (pend_w[b] == 1) model[b][pend_a[b] | 1] = {24'h0, pend_d[b][39:32]};
            if (pend_w[b] == 2) model[b][pend_a[b] | 1] = pend_d[b][63:32];
         end
         pend[b] = 1'b0;
      end
      @(negedge clk);
      wr_en = '0;
   endtask

   task automatic clear_model();
      for (int b = 0; b < 2; b++)
         for (int r = 0; r < 16; r++) model[b][r] = 32'h0;
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #2000000;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
   end

   initial begin
      clear_model();
      pend[0] = 0; pend[1] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      do_read(0, 0, 0, 0, "R9 reset A0");
      do_read(1, 1, 15, 2, "R9 reset B15");

      // R2 single word with high-bit halves
      wr_drive(0, 0, 3, 64'hFFFF_0000_DEAD_BEEF, "R2 write err");
      wr_commit();
      do_read(0, 0, 3, 0, "R2 word A3");
      do_read(0, 1, 2, 0, "R2 neighbour A2");
      do_read(1, 0, 3, 0, "R1 B3 untouched");

      // R3 64-bit pair
      wr_drive(0, 2, 4, 64'h1122_3344_5566_7788, "R3 write err");
      wr_commit();
      do_read(0, 0, 4, 2, "R3 pair A4");
      do_read(0, 1, 5, 0, "R3 odd word A5");

      // R4 40-bit write over prefilled odd register
      wr_drive(0, 0, 7, 64'hFFFF_FFFF, "R4 prefill err");
      wr_commit();
      wr_drive(0, 1, 6, 64'h5A5A_5AAB_CAFE_F00D, "R4 write err");
      wr_commit();
      do_read(0, 0, 7, 0, "R4 odd upper cleared");
      do_read(0, 1, 6, 1, "R4 pair40 read");

      // R5 wide reads of a fully populated pair
      wr_drive(1, 0, 9, 64'h1234_5678, "R5 prefill odd");
      wr_commit();
      wr_drive(1, 0, 8, 64'h9ABC_DEF0, "R5 prefill even");
      wr_commit();
      do_read(1, 0, 8, 1, "R5 read40 masks odd");
      do_read(1, 1, 8, 2, "R5 read64 full");

      // R6 odd address wide accesses
      wr_drive(0, 2, 5, 64'hDDDD_DDDD_EEEE_EEEE, "R6 odd write64 err");
      wr_commit();
      do_read(0, 0, 4, 2, "R6 pair unchanged");
      wr_drive(1, 1, 9, 64'h77_0000_0001, "R6 odd write40 err");
      wr_commit();
      do_read(1, 0, 8, 2, "R6 B pair unchanged");
      do_read(1, 1, 9, 2, "R6 odd read64");
      do_read(0, 1, 7, 1, "R6 odd read40");

      // R7 invalid width code
      wr_drive(0, 3, 4, 64'hAAAA_AAAA_BBBB_BBBB, "R7 bad width err");
      wr_commit();
      do_read(0, 0, 4, 2, "R7 pair unchanged");
      do_read(0, 1, 2, 3, "R7 bad width read");

      // R1 same register number in both banks at once
      wr_drive(0, 0, 12, 64'hA0A0_A0A0, "R1 A write err");
      wr_drive(1, 0, 12, 64'hB1B1_B1B1, "R1 B write err");
      wr_commit();
      do_read(0, 0, 12, 0, "R1 A12");
      do_read(1, 0, 12, 0, "R1 B12");

      // R10 two ports, different addresses and widths, same cycle
      rd_addr[0][0] = 4'd3;  rd_width[0][0] = 2'd0;
      do_read(0, 1, 4, 2, "R10 port1 pair A4");
      do_read(0, 0, 3, 0, "R10 port0 word A3");

      // R8 same-cycle read returns old value
      wr_drive(0, 0, 10, 64'h0BAD_F00D, "R8 write err");
      do_read(0, 0, 10, 0, "R8 old value");
      wr_commit();
      do_read(0, 0, 10, 0, "R8 new value");

      // R9 reset clears populated state
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      clear_model();
      do_read(0, 0, 4, 2, "R9 A4 pair cleared");
      do_read(1, 1, 8, 2, "R9 B8 pair cleared");
      do_read(0, 1, 10, 0, "R9 A10 cleared");

      repeat (2) @(posedge clk);
      finish_run();
   end

endmodule